// File: doc/BRIEF.md
# Read Four-Base Presence Vector Builder

This block takes one short DNA read and turns it into a 256-bit presence vector. Each bit of the vector stands for one of the 256 possible four-base strings. A bit is set when that string appears at least once anywhere in the read. Downstream filters can then compare two reads by ANDing their vectors and counting the ones, without touching the bases again.

The read arrives as a single wide input word. The word holds the bases at two bits each, a read number and a one-bit starter-initialise mark. After a read is accepted, the block slides a four-base window along it, `LANES` windows per clock. It folds each window into the vector as one bit. When the last window has been folded in, it presents the vector with the read number and mark. Both sides use a valid/ready handshake. A new read is accepted only after the previous result has been taken.

Top module: `read_kmer_vec`

## Requirements
- R1: Bases are coded A=00, C=01, T=10, G=11. In `in_word`, base i of the read sits in bits [2i+1:2i] for i = 0..READ_LEN-1. The read number occupies the next ID_W bits (bits [231:200] by default), and the starter mark is the top bit (bit 232 by default).
- R2: A window holding bases i..i+3 maps to the 8-bit index {base i, base i+1, base i+2, base i+3}, with base i in bits [7:6], and sets vector bit `out_vec[index]`.
- R3: A vector bit is 1 exactly when its four-base string occurs at least once in the read. All READ_LEN-3 windows are used, including the final one (bases 96..99 by default).
- R4: A four-base string that occurs many times in a read sets only its own bit. The number of ones equals the number of distinct four-base strings in the read.
- R5: The vector is cleared for every accepted read. No bit from an earlier read appears in a later result, and no window spans two reads.
- R6: `out_num` and `out_flag` equal the read number and the starter mark of the read the vector was built from.
- R7: After reset, `in_ready`=1 and `out_valid`=0.
- R8: `out_valid` rises exactly ceil((READ_LEN-3)/LANES) clocks after the clock edge that accepts a read (25 by default). `in_ready` is 0 from acceptance until the result is taken.
- R9: While `out_valid`=1 and `out_ready`=0, `out_vec`, `out_num` and `out_flag` hold their values and `out_valid` stays high. `out_valid` falls on the edge where `out_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can accept a read |
| in_word | input | 233 | Packed bases, read number and starter mark (R1) |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | 256 | Four-base presence vector |
| out_num | output | 32 | Read number of the result |
| out_flag | output | 1 | Starter mark of the result |

## Verification
The assertions assume that the consumer drops `out_ready` only as a plain level. They also assume that every `in_word` offered holds a fully defined read, since there is no partial-read or length field. The bench keeps to both assumptions. It changes inputs only on falling edges, always builds the complete 233-bit word, and holds `in_valid` for exactly one accepting edge. The bench also applies backpressure on the output. This exercises the hold property, and it exercises the claim that no read is accepted while a result is pending.

// File: rtl/kmer_pkg.sv
package kmer_pkg;
   typedef enum logic [1:0] {
      BASE_A = 2'b00,
      BASE_C = 2'b01,
      BASE_T = 2'b10,
      BASE_G = 2'b11
   } base_e;

   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_WALK = 2'd1,
      WS_DONE = 2'd2
   } walk_state_e;

   localparam int unsigned BASE_BITS = 2;
endpackage

// File: rtl/kmer_lane.sv
module kmer_lane #(
   parameter int unsigned K     = 4,
   parameter int unsigned BW    = kmer_pkg::BASE_BITS,
   localparam int unsigned IW   = K * BW,
   localparam int unsigned NBIT = 1 << IW
) (
   input  logic [IW-1:0]   win,
   input  logic            en,
   output logic [NBIT-1:0] hit
);
   logic [IW-1:0] idx;

   // first base of the window lands in the most significant slot
   always_comb begin
      idx = '0;
      for (int j = 0; j < int'(K); j++) begin
         idx[IW-1-j*BW -: BW] = win[j*BW +: BW];
      end
   end

   always_comb begin
      hit = '0;
      if (en) hit[idx] = 1'b1;
   end

   always_comb begin
      assert ($countones(hit) <= 1) else $error("AST_LANE_ONEHOT");   // R2
   end
endmodule

// File: rtl/kmer_accum.sv
module kmer_accum #(
   parameter int unsigned NBIT  = 256,
   parameter int unsigned LANES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  upd,
   input  logic [LANES*NBIT-1:0] hits,
   output logic [NBIT-1:0]       vec
);
   logic [NBIT-1:0] merged;

   always_comb begin
      merged = '0;
      for (int l = 0; l < int'(LANES); l++) merged = merged | hits[l*NBIT +: NBIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vec <= '0;
      else if (clr) vec <= '0;
      else if (upd) vec <= vec | merged;
   end

   AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (vec == '0)) else $error("AST_CLR_EMPTY");   // R5
   AST_GROW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !$isunknown(vec)) |=> ((vec & $past(vec)) == $past(vec))) else $error("AST_GROW_ONLY");   // R4
endmodule

// File: rtl/kmer_walk.sv
module kmer_walk
   import kmer_pkg::*;
#(
   parameter int unsigned NWIN  = 97,
   parameter int unsigned LANES = 4,
   localparam int unsigned PW   = $clog2(NWIN + LANES) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          out_ready,
   output logic          in_ready,
   output logic          out_valid,
   output logic          take,
   output logic          step,
   output logic [PW-1:0] pos
);
   walk_state_e st;
   logic        last_step;

   assign in_ready  = (st == WS_IDLE);
   assign out_valid = (st == WS_DONE);
   assign take      = in_ready && in_valid;
   assign step      = (st == WS_WALK);
   assign last_step = (32'(pos) + LANES) >= NWIN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= WS_IDLE;
         pos <= '0;
      end else begin
         unique case (st)
            WS_IDLE: if (in_valid) begin
               st  <= WS_WALK;
               pos <= '0;
            end
            WS_WALK: begin
               if (last_step) st <= WS_DONE;
               else           pos <= pos + PW'(LANES);
            end
            WS_DONE: if (out_ready) st <= WS_IDLE;
            default: st <= WS_IDLE;
         endcase
      end
   end

   AST_HS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid)) else $error("AST_HS_EXCL");   // R8
   AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (32'(pos) < NWIN)) else $error("AST_POS_RANGE");   // R3
   AST_DONE_FROM_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(step)) else $error("AST_DONE_FROM_WALK");   // R8
endmodule

// File: rtl/read_kmer_vec.sv
module read_kmer_vec #(
   parameter int unsigned READ_LEN = 100,
   parameter int unsigned K        = 4,
   parameter int unsigned ID_W     = 32,
   parameter int unsigned LANES    = 4,
   localparam int unsigned BW      = kmer_pkg::BASE_BITS,
   localparam int unsigned STR_W   = READ_LEN * BW,
   localparam int unsigned IN_W    = STR_W + ID_W + 1,
   localparam int unsigned NWIN    = READ_LEN - K + 1,
   localparam int unsigned IW      = K * BW,
   localparam int unsigned NBIT    = 1 << IW,
   localparam int unsigned PW      = $clog2(NWIN + LANES) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [IN_W-1:0] in_word,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [NBIT-1:0] out_vec,
   output logic [ID_W-1:0] out_num,
   output logic            out_flag
);
   initial begin
      assert (K >= 1 && K <= 6) else $error("K out of range");
      assert (LANES >= 1 && LANES + K - 1 <= READ_LEN) else $error("LANES out of range");
      assert (READ_LEN >= K) else $error("read shorter than window");
   end

   logic                  take, step;
   logic [PW-1:0]         pos;
   logic [STR_W-1:0]      str_q;
   logic [LANES*NBIT-1:0] hits;

   kmer_walk #(.NWIN(NWIN), .LANES(LANES)) u_walk (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
      .in_ready(in_ready), .out_valid(out_valid), .take(take), .step(step), .pos(pos)
   );

   // read string shifts down by one lane group per step, so lanes use fixed taps
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         str_q    <= '0;
         out_num  <= '0;
         out_flag <= 1'b0;
      end else if (take) begin
         str_q    <= in_word[STR_W-1:0];
         out_num  <= in_word[STR_W +: ID_W];
         out_flag <= in_word[IN_W-1];
      end else if (step) begin
         str_q    <= str_q >> (LANES * BW);
      end
   end

   for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
      logic en;
      assign en = step && ((32'(pos) + l) < NWIN);
      kmer_lane #(.K(K), .BW(BW)) u_lane (
         .win(str_q[l*BW +: IW]), .en(en), .hit(hits[l*NBIT +: NBIT])
      );
   end

   kmer_accum #(.NBIT(NBIT), .LANES(LANES)) u_accum (
      .clk(clk), .rst_n(rst_n), .clr(take), .upd(step), .hits(hits), .vec(out_vec)
   );

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) && $stable(out_num) && $stable(out_flag)))
      else $error("AST_OUT_HOLD");   // R9
   AST_VEC_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(out_vec) >= 1 && $countones(out_vec) <= NWIN)) else $error("AST_VEC_COUNT");   // R4
   AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (step || out_valid) |-> !in_ready) else $error("AST_NO_TAKE_BUSY");   // R8
   AST_ID_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> $stable(out_num) && $stable(out_flag)) else $error("AST_ID_STABLE");   // R6
endmodule

// File: tb/tb_read_kmer_vec.sv
module tb_read_kmer_vec;
   localparam int RL = 100;
   localparam int NWIN = RL - 3;
   localparam int LANES = 4;
   localparam int NSTEP = (NWIN + LANES - 1) / LANES;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [232:0] in_word = '0;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic [255:0] out_vec;
   logic [31:0]  out_num;
   logic         out_flag;
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   read_kmer_vec dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
      .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec), .out_num(out_num),
      .out_flag(out_flag)
   );

   function automatic logic [255:0] model(input logic [199:0] s);
      logic [255:0] v = '0;
      for (int w = 0; w < NWIN; w++) begin
         v[{s[2*w +: 2], s[2*(w+1) +: 2], s[2*(w+2) +: 2], s[2*(w+3) +: 2]}] = 1'b1;
      end
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // offers one read, waits for the result with hold cycles of backpressure, then takes it
   task automatic run_read(input logic [199:0] s, input logic [31:0] num, input logic flg, input int hold,
                           input string req, output logic [255:0] got);
      int n = 0;
      @(negedge clk);
      in_word  = {flg, num, s};
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk(in_ready == 1'b0, "R8", "in_ready low while walking", in_ready, 0);
      while (!out_valid && n < 1000) begin
         @(posedge clk); @(negedge clk); n++;
      end
      chk(n == NSTEP, "R8", "latency", n, NSTEP);
      got = out_vec;
      for (int h = 0; h < hold; h++) begin
         @(posedge clk); @(negedge clk);
         chk(out_valid && out_vec == got && in_ready == 1'b0, "R9", "hold under backpressure", out_vec, got);
      end
      chk(out_num == num, {req, "/R6"}, "read number", out_num, num);
      chk(out_flag == flg, "R6", "starter mark", out_flag, flg);
      out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      out_ready = 1'b0;
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R9", "result taken", {out_valid, in_ready}, 2'b01);
   endtask

   task automatic t_reset();
      chk(in_ready == 1'b1, "R7", "in_ready after reset", in_ready, 1);
      chk(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
   endtask

   task automatic t_uniform();
      logic [255:0] v;
      run_read({100{2'b11}}, 32'hA5A5_0001, 1'b1, 3, "R1", v);
      chk(v == (256'd1 << 255), "R1", "all G sets bit 255", v, 256'd1 << 255);
      run_read({100{2'b00}}, 32'h0000_0002, 1'b0, 0, "R5", v);
      chk(v == 256'd1, "R5", "all A after all G sets only bit 0", v, 256'd1);
   endtask

   task automatic t_order();
      logic [199:0] s = '0;
      logic [255:0] v;
      s[199:198] = 2'b01;   // last base C, rest A: tests final window and MSB order
      run_read(s, 32'd3, 1'b0, 0, "R2", v);
      chk(v == 256'h3, "R2", "AAAC maps to index 1", v, 256'h3);
      chk(v[1] == 1'b1, "R3", "final window used", v, 256'h2);
      s = '0;
      s[1:0] = 2'b10;       // first base T, rest A: TAAA maps to index 128
      run_read(s, 32'd4, 1'b1, 1, "R2", v);
      chk(v == ((256'd1 << 128) | 256'd1), "R2", "TAAA maps to index 128", v, (256'd1 << 128) | 256'd1);
   endtask

   task automatic t_repeat();
      logic [199:0] s;
      logic [255:0] v, e;
      for (int i = 0; i < RL; i++) s[2*i +: 2] = 2'(i % 4 == 0 ? 0 : i % 4 == 1 ? 1 : i % 4 == 2 ? 3 : 2);
      e = (256'd1 << 30) | (256'd1 << 120) | (256'd1 << 225) | (256'd1 << 135);
      run_read(s, 32'hDEAD_BEEF, 1'b1, 2, "R4", v);
      chk(v == e, "R4", "ACGT repeat gives four bits", v, e);
      chk($countones(v) == 4, "R4", "one bit per distinct string", $countones(v), 4);
   endtask

   task automatic t_random();
      logic [199:0] s;
      logic [255:0] v, e;
      for (int r = 0; r < 6; r++) begin
         for (int i = 0; i < 200; i += 32) s[i +: 32] = 32'($urandom);
         e = model(s);
         run_read(s, 32'($urandom), 1'(r), r % 3, "R3", v);
         chk(v == e, "R3", "random read vector", v, e);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_uniform();
      t_order();
      t_repeat();
      t_random();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule